// File: doc/BRIEF.md
# Serial Control Register Port

This block is the slave end of a four-wire control link (active-low select, serial clock, serial data in, serial data out with an output enable) that sets a bank of 8-bit configuration registers. Every transaction is a 16-bit frame. It holds a 2-bit device identifier, a direction flag, a 5-bit register index and one data byte. The most significant bit of each field is sent first. A frame whose identifier does not match is ignored completely.

All four link pins, the master clock and the active-low power-down pin are sampled by a free-running system clock through two-flop synchronizers. The serial clock edges are found in that clock domain. The system clock must be at least ten times the serial clock: a 50 MHz system clock supports the 5 MHz maximum serial rate. The whole register image is presented in parallel to the rest of the chip.

A watchdog counter checks the master clock. While the master clock has stopped, or while power-down is asserted, writes are discarded. Power-down also returns every register to its default value.

Top module: `serctl_port`

## Requirements
- R1: A frame is bits {id[1:0], dir, index[4:0], data[7:0]}, sent in that order with the most significant bit of each field first. Only id = 2'b01 is accepted. Any other id writes nothing and never enables the data output.
- R2: When dir = 1, the byte is written to register `index` on the 16th rising serial clock edge after select falls. The new value appears on `cfg_image[8*index +: 8]` four system cycles after that edge reaches the pin.
- R3: When dir = 0, the addressed byte is shifted out most significant bit first. The output changes on each falling serial clock edge, starting with the first falling edge after the 8th rising edge.
- R4: `sdo_oe` stays low while the header is being received. It goes high three system cycles after the first falling edge of a read's data phase. It returns low three system cycles after select goes high.
- R5: A write frame that ends (select high) before its 16th rising edge changes no register.
- R6: While `pwr_dn_n` is low, every register returns to its default value, (37*i + 5) mod 256 for register i, three system cycles after the pin falls.
- R7: Write frames completed while `pwr_dn_n` is low leave the registers at their defaults.
- R8: If no edge of `mclk` is seen for MCLK_TIMEOUT system cycles, writes are discarded. Writes resume once `mclk` edges return.
- R9: Indices at or above NUM_REGS (24 by default) read as zero, and writes to them change nothing.
- R10: A synchronous `rst` loads the defaults and drives `sdo_oe` and `sdo` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn_n | input | 1 | Active-low power-down, asynchronous pin |
| mclk | input | 1 | Master clock, monitored for activity |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the pad driving sdo |
| cfg_image | output | 8*NUM_REGS | Parallel image of all registers, register i at bits 8*i+7:8*i |

## Verification
Every input change passes through two synchronizer flops before the logic sees it. An output enable change is therefore due three system cycles after its pin event. A committed write, or the reset to defaults caused by power-down, is due four cycles after the event, or three for power-down. The bench keeps a behavioural model of the register image and the expected enable, and updates it on exactly those cycles. It compares the model against the ports half a cycle after every rising edge. Read bits are sampled just before each rising serial clock edge, five system cycles after the falling edge that launched them, so the data has long since settled.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  localparam int MAX_REGS = 32;
  localparam int FRAME_LEN = 16;
  localparam int HDR_LEN = 8;
  localparam logic [1:0] DEV_ID = 2'b01;

  function automatic logic [MAX_REGS*8-1:0] default_image();
    logic [MAX_REGS*8-1:0] img;
    for (int i = 0; i < MAX_REGS; i++) img[i*8 +: 8] = 8'((i * 37 + 5) % 256);
    return img;
  endfunction
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) begin
          meta[g] <= RST_VAL[g];
          q[g]    <= RST_VAL[g];
        end else begin
          meta[g] <= d[g];
          q[g]    <= meta[g];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/serctl_mclk_mon.sv
module serctl_mclk_mon #(
  parameter int TIMEOUT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic mclk_s,
  output logic mclk_ok
);
  localparam int CW = $clog2(TIMEOUT + 1);
  logic [CW-1:0] idle_cnt;
  logic          mclk_q;
  logic          edge_seen;

  assign edge_seen = mclk_s ^ mclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mclk_q   <= 1'b0;
      idle_cnt <= '0;
      mclk_ok  <= 1'b1;
    end else begin
      mclk_q <= mclk_s;
      if (edge_seen) begin
        idle_cnt <= '0;
        mclk_ok  <= 1'b1;
      end else if (idle_cnt == CW'(TIMEOUT)) begin
        mclk_ok <= 1'b0;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  // R8: any master clock edge re-enables writes on the next cycle
  a_r8_edge_revives: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> mclk_ok);
endmodule

// File: rtl/serctl_frame.sv
module serctl_frame
  import serctl_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int CNT_W  = $clog2(FRAME_LEN + 1);
  localparam int DATA_W = FRAME_LEN - HDR_LEN;

  logic                 sclk_q;
  logic                 rise, fall;
  logic [CNT_W-1:0]     bit_cnt;
  logic [FRAME_LEN-2:0] shreg;
  logic [FRAME_LEN-1:0] nxt;
  logic                 rd_active;
  logic [DATA_W-1:0]    out_sr;

  assign rise = sclk_s & ~sclk_q;
  assign fall = ~sclk_s & sclk_q;
  assign nxt  = {shreg, sdi_s};

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b1;
    else     sclk_q <= sclk_s;
  end

  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      rd_active <= 1'b0;
      rd_addr   <= '0;
      out_sr    <= '0;
      sdo       <= 1'b0;
      sdo_oe    <= 1'b0;
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (rise && bit_cnt < CNT_W'(FRAME_LEN)) begin
        shreg   <= nxt[FRAME_LEN-2:0];
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(HDR_LEN - 1) && nxt[7:6] == DEV_ID && !nxt[5]) begin
          rd_active <= 1'b1;
          rd_addr   <= nxt[ADDR_W-1:0];
        end
        if (bit_cnt == CNT_W'(FRAME_LEN - 1) && nxt[15:14] == DEV_ID && nxt[13]) begin
          wr_stb  <= 1'b1;
          wr_addr <= nxt[8 +: ADDR_W];
          wr_data <= nxt[7:0];
        end
      end
      if (fall && rd_active) begin
        if (!sdo_oe) begin
          sdo_oe <= 1'b1;
          out_sr <= rd_data;
          sdo    <= rd_data[DATA_W-1];
        end else begin
          out_sr <= {out_sr[DATA_W-2:0], 1'b0};
          sdo    <= out_sr[DATA_W-2];
        end
      end
    end
  end

  // R4: deselecting always releases the output on the next cycle
  a_r4_release_on_deselect: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !sdo_oe);
  // R1: the output is only ever enabled inside a matching read frame
  a_r1_drive_needs_read: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> rd_active);
  // R2: a frame commits at most one write, as a single-cycle strobe
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);
endmodule

// File: rtl/serctl_regfile.sv
module serctl_regfile #(
  parameter int NUM_REGS = 24,
  parameter int ADDR_W = 5,
  parameter logic [8*32-1:0] DEFAULTS = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pdn_s,
  input  logic                  mclk_ok,
  input  logic                  wr_stb,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [7:0]            rd_data,
  output logic [8*NUM_REGS-1:0] cfg_image
);
  logic [7:0] regs [NUM_REGS];
  logic       wr_ok;

  assign wr_ok = wr_stb & pdn_s & mclk_ok;

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst || !pdn_s)
          regs[g] <= DEFAULTS[g*8 +: 8];
        else if (wr_ok && wr_addr == ADDR_W'(g))
          regs[g] <= wr_data;
      end
      assign cfg_image[g*8 +: 8] = regs[g];
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) < NUM_REGS) rd_data = regs[rd_addr];
  end

  // R6: power-down forces the default image on the following cycle
  a_r6_pdn_defaults: assert property (@(posedge clk) disable iff (rst)
    !pdn_s |=> cfg_image == DEFAULTS[8*NUM_REGS-1:0]);
  // R8: a strobe arriving while the master clock is missing changes nothing
  a_r8_no_write_without_mclk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !mclk_ok && pdn_s) |=> $stable(cfg_image));
endmodule

// File: rtl/serctl_port.sv
module serctl_port
  import serctl_pkg::*;
#(
  parameter int NUM_REGS = 24,
  parameter int MCLK_TIMEOUT = 32,
  parameter logic [8*MAX_REGS-1:0] REG_DEFAULTS = serctl_pkg::default_image()
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pwr_dn_n,
  input  logic                  mclk,
  input  logic                  cs_n,
  input  logic                  sclk,
  input  logic                  sdi,
  output logic                  sdo,
  output logic                  sdo_oe,
  output logic [8*NUM_REGS-1:0] cfg_image
);
  localparam int ADDR_W = 5;

  logic [4:0]        pins_s;
  logic              pdn_s, mclk_s, cs_s, sclk_s, sdi_s;
  logic              mclk_ok;
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [7:0]        wr_data, rd_data;

  serctl_sync #(.W(5), .RST_VAL(5'b10110)) u_sync (
    .clk(clk), .rst(rst),
    .d({pwr_dn_n, mclk, cs_n, sclk, sdi}),
    .q(pins_s)
  );
  assign {pdn_s, mclk_s, cs_s, sclk_s, sdi_s} = pins_s;

  serctl_mclk_mon #(.TIMEOUT(MCLK_TIMEOUT)) u_mon (
    .clk(clk), .rst(rst), .mclk_s(mclk_s), .mclk_ok(mclk_ok)
  );

  serctl_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst(rst), .cs_s(cs_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  serctl_regfile #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DEFAULTS(REG_DEFAULTS)) u_regs (
    .clk(clk), .rst(rst), .pdn_s(pdn_s), .mclk_ok(mclk_ok),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cfg_image(cfg_image)
  );
endmodule

// File: tb/serctl_port_tb.sv
`timescale 1ns/1ps
module serctl_port_tb_top;
  localparam int NREG = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_dn_n = 1'b1;
  logic mclk = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b1;
  logic sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [8*NREG-1:0] cfg_image;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit cmp_on = 0;
  bit mclk_run = 1;
  bit exp_oe = 0;
  logic [7:0] model [NREG];

  always #10 clk = ~clk;

  serctl_port dut_i (
    .clk(clk), .rst(rst), .pwr_dn_n(pwr_dn_n), .mclk(mclk),
    .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .cfg_image(cfg_image)
  );

  function automatic logic [7:0] dflt(int i);
    return 8'((37 * i + 5) % 256);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (mclk_run) begin
        ph++;
        if (ph == 2) begin mclk = ~mclk; ph = 0; end
      end
    end
  end

  // per-cycle comparison against the behavioural model
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (cmp_on) begin
        for (int i = 0; i < NREG; i++)
          check(cfg_image[i*8 +: 8] == model[i], "R2 register image", cfg_image[i*8 +: 8], model[i]);
        check(sdo_oe == exp_oe, "R4 output enable", sdo_oe, exp_oe);
      end
    end
  end

  task automatic frame(input logic [1:0] id, input bit dir, input logic [4:0] idx,
                       input logic [7:0] wdata, input int nbits, input string req,
                       output logic [7:0] rdata);
    logic [15:0] word;
    bit valid, drive, commit;
    logic [7:0] expect_rd;
    word   = {id, dir, idx, wdata};
    valid  = (id == 2'b01);
    drive  = valid && !dir && nbits >= 9;
    commit = valid && dir && nbits == 16 && pwr_dn_n && mclk_run && int'(idx) < NREG;
    expect_rd = (int'(idx) < NREG) ? model[idx] : 8'h00;
    rdata = '0;
    cs_n = 1'b0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      sdi  = word[15-i];
      repeat (3) @(negedge clk);
      if (i == 8 && drive) exp_oe = 1'b1;
      repeat (2) @(negedge clk);
      if (drive && i >= 8) begin
        rdata[15-i] = sdo;
        check(sdo == expect_rd[15-i], {req, " read bit"}, sdo, expect_rd[15-i]);
      end
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      if (i == 15 && commit) model[idx] = wdata;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_oe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] rd;
    for (int i = 0; i < NREG; i++) model[i] = dflt(i);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1;
    // R10: reset state
    check(sdo_oe == 1'b0 && sdo == 1'b0, "R10 output idle", {sdo_oe, sdo}, 0);
    check(cfg_image[8*7 +: 8] == dflt(7), "R10 default reg7", cfg_image[8*7 +: 8], dflt(7));
    repeat (20) @(negedge clk);

    // R2 / R3: write then read back
    frame(2'b01, 1'b1, 5'd3, 8'hA5, 16, "R2", rd);
    check(cfg_image[8*3 +: 8] == 8'hA5, "R2 write reg3", cfg_image[8*3 +: 8], 8'hA5);
    frame(2'b01, 1'b0, 5'd3, 8'h00, 16, "R3", rd);
    check(rd == 8'hA5, "R3 read reg3", rd, 8'hA5);
    frame(2'b01, 1'b1, 5'd0, 8'h3C, 16, "R2", rd);
    frame(2'b01, 1'b1, 5'd23, 8'hFF, 16, "R2", rd);
    frame(2'b01, 1'b0, 5'd23, 8'h00, 16, "R3", rd);
    check(rd == 8'hFF, "R3 read top reg", rd, 8'hFF);
    frame(2'b01, 1'b0, 5'd10, 8'h00, 16, "R3", rd);
    check(rd == dflt(10), "R3 read default reg10", rd, dflt(10));

    // R1: wrong device id
    frame(2'b10, 1'b1, 5'd3, 8'h00, 16, "R1", rd);
    check(cfg_image[8*3 +: 8] == 8'hA5, "R1 foreign write ignored", cfg_image[8*3 +: 8], 8'hA5);
    frame(2'b00, 1'b0, 5'd3, 8'h00, 16, "R1", rd);
    check(sdo_oe == 1'b0, "R1 foreign read not driven", sdo_oe, 0);

    // R5: short frame
    frame(2'b01, 1'b1, 5'd5, 8'h12, 10, "R5", rd);
    frame(2'b01, 1'b1, 5'd5, 8'h12, 15, "R5", rd);
    check(cfg_image[8*5 +: 8] == dflt(5), "R5 short frame dropped", cfg_image[8*5 +: 8], dflt(5));

    // R9: indices beyond the bank
    frame(2'b01, 1'b0, 5'd30, 8'h00, 16, "R9", rd);
    check(rd == 8'h00, "R9 unimplemented reads zero", rd, 0);
    frame(2'b01, 1'b1, 5'd28, 8'h99, 16, "R9", rd);
    frame(2'b01, 1'b0, 5'd28, 8'h00, 16, "R9", rd);
    check(rd == 8'h00, "R9 unimplemented write lost", rd, 0);

    // R8: master clock missing
    mclk_run = 0;
    repeat (100) @(negedge clk);
    frame(2'b01, 1'b1, 5'd4, 8'h77, 16, "R8", rd);
    frame(2'b01, 1'b0, 5'd4, 8'h00, 16, "R8", rd);
    check(rd == dflt(4), "R8 write blocked without mclk", rd, dflt(4));
    mclk_run = 1;
    repeat (20) @(negedge clk);
    frame(2'b01, 1'b1, 5'd4, 8'h77, 16, "R8", rd);
    check(cfg_image[8*4 +: 8] == 8'h77, "R8 write resumes", cfg_image[8*4 +: 8], 8'h77);

    // R6 / R7: power-down
    pwr_dn_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NREG; i++) model[i] = dflt(i);
    repeat (2) @(negedge clk);
    check(cfg_image[8*3 +: 8] == dflt(3), "R6 defaults restored", cfg_image[8*3 +: 8], dflt(3));
    frame(2'b01, 1'b1, 5'd6, 8'h5A, 16, "R7", rd);
    check(cfg_image[8*6 +: 8] == dflt(6), "R7 write during power-down", cfg_image[8*6 +: 8], dflt(6));
    pwr_dn_n = 1'b1;
    repeat (10) @(negedge clk);
    frame(2'b01, 1'b0, 5'd0, 8'h00, 16, "R6", rd);
    check(rd == dflt(0), "R6 reg0 default after power-down", rd, dflt(0));

    repeat (10) @(negedge clk);
    cmp_on = 0;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule